// File: doc/BRIEF.md
# Mode-Configurable Transfer Count Unit

This block keeps the transfer count for a descriptor-driven data transfer engine. When the engine fetches a descriptor, it loads a 16-bit count word and a 2-bit mode field through a load strobe. After that, each data transfer is signalled by a one-cycle transfer strobe, and the unit updates its count.

The unit has two ways of counting:

- **Normal mode.** The whole 16-bit word counts down. When the last transfer happens, a one-cycle done pulse is raised and the counter stays at zero.
- **Repeat and block modes.** The upper byte holds a reload value (in block mode, the block size) and the lower byte counts down. When the lower byte would reach zero, it is refilled from the upper byte in the same cycle, and a one-cycle wrap pulse is raised.

In both ways of counting, a loaded value of zero stands for the largest count that the counter width allows. The unit also drives a write-back word: the count value that will be stored at the next clock edge, for the engine to write back into the descriptor.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, `count_o` is 0000h, and `done_o`, `wrap_o` and `mode_err_o` are all 0.
- R2: A load strobe stores `load_word_i` and `load_mode_i`, and they show on the outputs one cycle later. If a transfer strobe arrives in the same cycle as a load strobe, the load wins and the transfer has no effect.
- R3: Mode 00b is normal mode. In this mode, each transfer strobe lowers the full 16-bit `count_o` by one.
- R4: In normal mode, a start value N gives exactly N transfers, and a start value of 0000h gives 65536. On the last transfer, `count_o` becomes 0000h and `done_o` is high for one cycle. Transfer strobes after that leave the count at zero and raise no further done pulse.
- R5: Mode 01b is repeat mode. In this mode, each transfer lowers `count_o[7:0]` by one, and `count_o[15:8]` never changes except on a load.
- R6: In the 8-bit modes, the transfer that would bring the lower byte to 00h instead copies the upper byte into the lower byte, and `wrap_o` is high for one cycle. A lower byte of 00h stands for 256 transfers.
- R7: Mode 10b is block mode. It counts and reloads exactly like repeat mode, and the upper byte is the block size.
- R8: Mode 11b is reserved. While it is selected, `mode_err_o` is 1 and transfer strobes leave `count_o` unchanged.
- R9: `wb_word_o` shows, within the same cycle, the count that the next clock edge will store. While a transfer strobe is high, that is the updated count.
- R10: With neither strobe asserted, `count_o` holds its value and both pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for the count word and mode from the descriptor |
| load_word_i | input | 16 | Count word to load |
| load_mode_i | input | 2 | Mode to load: 00b normal, 01b repeat, 10b block, 11b reserved |
| xfer_i | input | 1 | One-cycle strobe for each completed data transfer |
| count_o | output | 16 | Live counter value |
| done_o | output | 1 | One-cycle pulse on the final transfer in normal mode |
| wrap_o | output | 1 | One-cycle pulse on a reload (repeat or block end) |
| mode_err_o | output | 1 | High while the reserved mode is selected |
| wb_word_o | output | 16 | Count word to write back into the descriptor (next-state value) |

## Verification
The bench runs a normal-mode count that starts from 0000h through all 65536 transfers. A design that treats zero as empty would raise done at once or never count; a design that stops one transfer early or late would put the done pulse in the wrong place. The bench checks the byte modes with a start byte of 00h, expecting 256 transfers before the wrap, and with small block sizes, where it checks that the lower byte jumps straight to the upper byte and never shows 00h. Further directed cases cover:

- strobes sent after the final transfer, which a design without an end-of-count guard would let wrap to FFFFh;
- a load and a transfer in the same cycle, which must not lose the load;
- transfer strobes under the reserved mode, which must be ignored.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
    parameter int unsigned CNT_W  = 16;
    localparam int unsigned LANE_W = CNT_W / 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_BLOCK  = 2'b10,
        MODE_RSVD   = 2'b11
    } xmode_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        xmode_e           mode;
        logic             armed;
        logic             done;
        logic             wrap;
    } xcnt_state_t;
endpackage

// File: rtl/xcnt_dec.sv
module xcnt_dec #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dec_o,
    output logic         is_one_o
);
    // Count-down arithmetic for one lane; zero wraps to all ones (max count).
    always_comb begin
        dec_o    = val_i - W'(1);
        is_one_o = (val_i == W'(1));
    end
endmodule

// File: rtl/xcnt_step.sv
module xcnt_step
    import xcnt_pkg::*;
(
    input  xcnt_state_t cur_i,
    input  logic        xfer_i,
    output xcnt_state_t nxt_o
);
    logic [CNT_W-1:0]  full_dec;
    logic              full_one;
    logic [LANE_W-1:0] low_dec;
    logic              low_one;

    xcnt_dec #(.W(CNT_W)) u_full (
        .val_i    (cur_i.cnt),
        .dec_o    (full_dec),
        .is_one_o (full_one)
    );

    xcnt_dec #(.W(LANE_W)) u_low (
        .val_i    (cur_i.cnt[LANE_W-1:0]),
        .dec_o    (low_dec),
        .is_one_o (low_one)
    );

    always_comb begin
        nxt_o      = cur_i;
        nxt_o.done = 1'b0;
        nxt_o.wrap = 1'b0;
        if (xfer_i) begin
            unique case (cur_i.mode)
                MODE_NORMAL: begin
                    if (cur_i.armed) begin
                        nxt_o.cnt = full_dec;
                        if (full_one) begin
                            nxt_o.done  = 1'b1;
                            nxt_o.armed = 1'b0;
                        end
                    end
                end
                MODE_REPEAT, MODE_BLOCK: begin
                    if (low_one) begin
                        nxt_o.cnt[LANE_W-1:0] = cur_i.cnt[CNT_W-1:LANE_W];
                        nxt_o.wrap            = 1'b1;
                    end else begin
                        nxt_o.cnt[LANE_W-1:0] = low_dec;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
    import xcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_word_i,
    input  logic [1:0]       load_mode_i,
    input  logic             xfer_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             wrap_o,
    output logic             mode_err_o,
    output logic [CNT_W-1:0] wb_word_o
);
    xcnt_state_t state_q, state_d, step_nxt;

    xcnt_step u_step (
        .cur_i  (state_q),
        .xfer_i (xfer_i),
        .nxt_o  (step_nxt)
    );

    always_comb begin
        if (load_i) begin
            state_d       = '0;
            state_d.cnt   = load_word_i;
            state_d.mode  = xmode_e'(load_mode_i);
            state_d.armed = 1'b1;
        end else begin
            state_d = step_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_o    = state_q.cnt;
    assign done_o     = state_q.done;
    assign wrap_o     = state_q.wrap;
    assign mode_err_o = (state_q.mode == MODE_RSVD);
    assign wb_word_o  = state_d.cnt;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_word_i)));

    // R4
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == '0) && !wrap_o);

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && state_q.mode != MODE_NORMAL) |=> $stable(count_o[CNT_W-1:LANE_W]));

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (count_o[LANE_W-1:0] == count_o[CNT_W-1:LANE_W]));

    // R8
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err_o && !load_i) |=> $stable(count_o) && !done_o && !wrap_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !xfer_i) |=> $stable(count_o) && !done_o && !wrap_o);
endmodule

// File: tb/xfer_count_unit_test.sv
module xfer_count_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_word_i = '0;
    logic [1:0]  load_mode_i = '0;
    logic        xfer_i = 1'b0;
    logic [15:0] count_o, wb_word_o;
    logic        done_o, wrap_o, mode_err_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    xfer_count_unit uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_word_i(load_word_i),
        .load_mode_i(load_mode_i), .xfer_i(xfer_i), .count_o(count_o),
        .done_o(done_o), .wrap_o(wrap_o), .mode_err_o(mode_err_o),
        .wb_word_o(wb_word_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] w, input logic [1:0] m);
        @(negedge clk);
        load_i = 1'b1; load_word_i = w; load_mode_i = m;
        @(posedge clk); #1;
        load_i = 1'b0;
    endtask

    // Applies n transfer strobes; counts done and wrap pulses seen.
    task automatic run_xfers(input int n, output int dones, output int wraps);
        dones = 0; wraps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xfer_i = 1'b1;
            @(posedge clk); #1;
            xfer_i = 1'b0;
            dones += int'(done_o);
            wraps += int'(wrap_o);
        end
    endtask

    task automatic t_reset;
        check("R1 count", count_o, 16'h0000);
        check("R1 flags", {done_o, wrap_o, mode_err_o}, 3'b000);
    endtask

    task automatic t_normal_small;
        int d, w;
        do_load(16'h0005, 2'b00);
        check("R2 loaded", count_o, 16'h0005);
        run_xfers(1, d, w);
        check("R3 dec", count_o, 16'h0004);
        run_xfers(3, d, w);
        check("R4 no early done", d, 0);
        run_xfers(1, d, w);
        check("R4 done pulse", d, 1);
        check("R4 at zero", count_o, 16'h0000);
        run_xfers(3, d, w);
        check("R4 hold after done", count_o, 16'h0000);
        check("R4 no extra done", d, 0);
    endtask

    task automatic t_normal_max;
        int d, w;
        do_load(16'h0000, 2'b00);
        run_xfers(1, d, w);
        check("R4 zero start first", count_o, 16'hFFFF);
        run_xfers(65534, d, w);
        check("R4 zero start no done", d, 0);
        check("R4 zero start near end", count_o, 16'h0001);
        run_xfers(1, d, w);
        check("R4 65536th done", d, 1);
        check("R4 65536th count", count_o, 16'h0000);
    endtask

    task automatic t_repeat;
        int d, w;
        do_load(16'h0303, 2'b01);
        run_xfers(2, d, w);
        check("R5 low dec", count_o, 16'h0301);
        run_xfers(1, d, w);
        check("R6 wrap pulse", w, 1);
        check("R6 reload", count_o, 16'h0303);
        run_xfers(3, d, w);
        check("R6 second wrap", w, 1);
        check("R5 upper kept", count_o[15:8], 8'h03);
        check("R5 no done", d, 0);
    endtask

    task automatic t_repeat_256;
        int d, w;
        do_load(16'h0000, 2'b01);
        run_xfers(1, d, w);
        check("R6 00h start", count_o, 16'h00FF);
        run_xfers(254, d, w);
        check("R6 no early wrap", w, 0);
        run_xfers(1, d, w);
        check("R6 256th wrap", w, 1);
        check("R6 256th count", count_o, 16'h0000);
    endtask

    task automatic t_block;
        int d, w;
        do_load(16'h0202, 2'b10);
        run_xfers(1, d, w);
        check("R7 dec", count_o, 16'h0201);
        run_xfers(1, d, w);
        check("R7 block end", w, 1);
        check("R7 reload", count_o, 16'h0202);
    endtask

    task automatic t_reserved;
        int d, w;
        do_load(16'h1234, 2'b11);
        check("R8 err flag", mode_err_o, 1'b1);
        run_xfers(4, d, w);
        check("R8 ignored", count_o, 16'h1234);
        check("R8 no pulses", d + w, 0);
        do_load(16'h0001, 2'b00);
        check("R8 err clears", mode_err_o, 1'b0);
    endtask

    task automatic t_priority;
        do_load(16'h0900, 2'b00);
        @(negedge clk);
        load_i = 1'b1; load_word_i = 16'h0040; load_mode_i = 2'b00; xfer_i = 1'b1;
        @(posedge clk); #1;
        load_i = 1'b0; xfer_i = 1'b0;
        check("R2 load wins", count_o, 16'h0040);
    endtask

    task automatic t_writeback;
        do_load(16'h0010, 2'b00);
        @(negedge clk);
        xfer_i = 1'b1;
        #1;
        check("R9 wb next", wb_word_o, 16'h000F);
        check("R9 count unchanged", count_o, 16'h0010);
        @(posedge clk); #1;
        xfer_i = 1'b0;
        check("R9 stored", count_o, 16'h000F);
        #1;
        check("R9 wb idle", wb_word_o, 16'h000F);
    endtask

    task automatic t_idle;
        do_load(16'h0505, 2'b01);
        repeat (5) @(posedge clk);
        #1;
        check("R10 hold", count_o, 16'h0505);
        check("R10 no pulses", {done_o, wrap_o}, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_normal_small();
        t_normal_max();
        t_repeat();
        t_repeat_256();
        t_block();
        t_reserved();
        t_priority();
        t_writeback();
        t_idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule